// File: doc/BRIEF.md
# Phase-Change Memory Read/Write Sequencer

This block sequences accesses to a 256 x 256 array of resistive phase-change cells. A client issues one request at a time on a synchronous port: a 12-bit address, a write-data word and a read/write flag. The sequencer latches the request, raises `busy`, and steps through timed array phases. A write drives a current pulse into one column of every column group. The data bit of each driver picks a set bias for a 1 or a reset bias for a 0. The written columns are then discharged. A read precharges the selected columns, waits a settle time, strobes the sense amplifiers and returns the sensed word with a one-cycle valid flag. A read leaves the cells unchanged, so no write-back follows it.

Each phase length comes from its own configuration input. The write pulse is clamped so that it never exceeds the programming limit of 400 ns, which is 40 cycles at 100 MHz. A mode input chooses how the cells store data. In single-ended mode each column group holds one bit of a 16-bit word. In differential mode each bit is stored in a pair of neighbouring groups as a value and its complement, and the word is 8 bits wide. The analog sense path, the bias levels and the cell physics lie outside the block.

Top module: `pcm_seq`

## Requirements
- R1: After reset `busy`, `row_en`, `pre_en`, `sa_strobe` and `rd_valid` are 0, and `wr_en`, `wr_bias` and `dis_en` are all zero.
- R2: While an access drives the array (write pulse, precharge, settle, sense), `row_en` is 1, `row_addr` equals request address bits [7:0] and `col_sel` equals request address bits [11:8].
- R3: During a write pulse, `wr_en` has exactly one bit set in each of the 16 groups, at column g*16 + col_sel. In single-ended mode `wr_bias` of the column in group g equals write-data bit g (1 = set bias). `wr_bias` is 0 on every column whose driver is off.
- R4: The write pulse lasts `cfg_pulse` cycles. A value of 0 counts as 1, and values above 40 are clamped to 40.
- R5: Directly after the pulse, `dis_en` marks the same columns that were driven, for max(`cfg_discharge`,1) cycles, with all drivers off. `busy` then falls.
- R6: A read asserts `pre_en` for max(`cfg_precharge`,1) cycles, then holds a settle gap of max(`cfg_settle`,1) cycles, then asserts `sa_strobe` for max(`cfg_sense`,1) cycles. These phases never overlap one another or a write phase.
- R7: `rd_valid` is high for exactly one cycle, the first cycle after `sa_strobe` falls. In single-ended mode `rd_data` bit g then equals `sa_out` bit g as sampled on the last strobe cycle.
- R8: In differential mode a write sets the bias of group 2i to data bit i and of group 2i+1 to the inverse of that bit, for i = 0..7.
- R9: In differential mode a read returns bit i = 1 exactly when `sa_out[2i]` is 1 and `sa_out[2i+1]` is 0. Bits 15:8 of `rd_data` are 0.
- R10: A request is accepted only while `busy` is 0. A request presented while `busy` is 1 is ignored and never reaches the array.
- R11: A read enables no write driver and does not alter stored data, so repeated reads return the same word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, taken when not busy |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | [11:8] column within group, [7:0] row |
| req_wdata | input | 16 | Write data (bits 7:0 used in differential mode) |
| diff_mode | input | 1 | 1 = complementary-pair storage, sampled with the request |
| cfg_pulse | input | 8 | Write pulse cycles (clamped 1..40) |
| cfg_discharge | input | 8 | Discharge cycles (0 counts as 1) |
| cfg_precharge | input | 8 | Precharge cycles (0 counts as 1) |
| cfg_settle | input | 8 | Settle cycles (0 counts as 1) |
| cfg_sense | input | 8 | Sense strobe cycles (0 counts as 1) |
| busy | output | 1 | Access in progress |
| row_en | output | 1 | Row line active |
| row_addr | output | 8 | Selected row |
| col_sel | output | 4 | Column selected within every group |
| wr_en | output | 256 | Per-column write driver enable |
| wr_bias | output | 256 | Per-column bias choice, 1 = set, 0 = reset |
| dis_en | output | 256 | Per-column discharge |
| pre_en | output | 1 | Precharge of the selected columns |
| sa_strobe | output | 1 | Sense amplifier strobe |
| sa_out | input | 16 | Sense amplifier outputs, one per group |
| rd_data | output | 16 | Read data |
| rd_valid | output | 1 | One-cycle read data valid |

## Verification
The assertions assume that `sa_out` is meaningful only while `sa_strobe` is high, and that the configuration inputs stay constant while an access is in flight. The bench changes them only between accesses, while `busy` is low. The pulse-bound assertion also assumes that nothing outside the sequencer drives the write drivers. For that reason the bench's array model only observes `wr_en`. The bench sets `sa_out` from that model on the falling edge during the strobe and clears it otherwise, so the sensed value is stable at the capture edge.

// File: rtl/pcm_seq.sv
module pcm_seq #(
  parameter int ROW_BITS  = 8,
  parameter int GROUPS    = 16,
  parameter int GSIZE     = 16,
  parameter int CNT_W     = 8,
  parameter int MAX_PULSE = 40,
  localparam int SEL_W = $clog2(GSIZE),
  localparam int AW    = ROW_BITS + SEL_W,
  localparam int NCOL  = GROUPS * GSIZE,
  localparam int HALF  = GROUPS / 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [AW-1:0]       req_addr,
  input  logic [GROUPS-1:0]   req_wdata,
  input  logic                diff_mode,
  input  logic [CNT_W-1:0]    cfg_pulse,
  input  logic [CNT_W-1:0]    cfg_discharge,
  input  logic [CNT_W-1:0]    cfg_precharge,
  input  logic [CNT_W-1:0]    cfg_settle,
  input  logic [CNT_W-1:0]    cfg_sense,
  output logic                busy,
  output logic                row_en,
  output logic [ROW_BITS-1:0] row_addr,
  output logic [SEL_W-1:0]    col_sel,
  output logic [NCOL-1:0]     wr_en,
  output logic [NCOL-1:0]     wr_bias,
  output logic [NCOL-1:0]     dis_en,
  output logic                pre_en,
  output logic                sa_strobe,
  input  logic [GROUPS-1:0]   sa_out,
  output logic [GROUPS-1:0]   rd_data,
  output logic                rd_valid
);

  typedef enum logic [2:0] {S_IDLE, S_PULSE, S_DIS, S_PRE, S_SETTLE, S_SENSE} st_t;

  localparam logic [CNT_W-1:0] PMAX = CNT_W'(MAX_PULSE);
  localparam logic [CNT_W-1:0] ONE  = CNT_W'(1);

  st_t              st;
  logic [CNT_W-1:0] cnt;
  logic [AW-1:0]    a_q;
  logic [GROUPS-1:0] d_q;
  logic             m_q;
  logic [GROUPS-1:0] grp_bias;
  logic [GROUPS-1:0] sensed;
  logic [CNT_W-1:0] pulse_len;

  function automatic logic [CNT_W-1:0] at_least1(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  assign pulse_len = (cfg_pulse == '0) ? ONE : (cfg_pulse > PMAX) ? PMAX : cfg_pulse;

  assign busy      = (st != S_IDLE);
  assign row_en    = (st == S_PULSE) || (st == S_PRE) || (st == S_SETTLE) || (st == S_SENSE);
  assign row_addr  = a_q[ROW_BITS-1:0];
  assign col_sel   = a_q[AW-1:ROW_BITS];
  assign pre_en    = (st == S_PRE);
  assign sa_strobe = (st == S_SENSE);

  for (genvar g = 0; g < GROUPS; g++) begin : g_grp
    if (g % 2 == 0) begin : g_even
      assign grp_bias[g] = m_q ? d_q[g/2] : d_q[g];
    end else begin : g_odd
      assign grp_bias[g] = m_q ? ~d_q[g/2] : d_q[g];
    end
    if (g < HALF) begin : g_lo
      assign sensed[g] = m_q ? (sa_out[2*g] & ~sa_out[2*g+1]) : sa_out[g];
    end else begin : g_hi
      assign sensed[g] = m_q ? 1'b0 : sa_out[g];
    end
    for (genvar c = 0; c < GSIZE; c++) begin : g_col
      wire hit = (col_sel == SEL_W'(c));
      assign wr_en[g*GSIZE+c]   = (st == S_PULSE) && hit;
      assign wr_bias[g*GSIZE+c] = (st == S_PULSE) && hit && grp_bias[g];
      assign dis_en[g*GSIZE+c]  = (st == S_DIS) && hit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      a_q      <= '0;
      d_q      <= '0;
      m_q      <= 1'b0;
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      case (st)
        S_IDLE: if (req_valid) begin
          a_q <= req_addr;
          d_q <= req_wdata;
          m_q <= diff_mode;
          if (req_write) begin
            st  <= S_PULSE;
            cnt <= pulse_len - ONE;
          end else begin
            st  <= S_PRE;
            cnt <= at_least1(cfg_precharge) - ONE;
          end
        end
        S_PULSE: if (cnt == '0) begin
          st  <= S_DIS;
          cnt <= at_least1(cfg_discharge) - ONE;
        end else cnt <= cnt - ONE;
        S_DIS: if (cnt == '0) st <= S_IDLE;
               else cnt <= cnt - ONE;
        S_PRE: if (cnt == '0) begin
          st  <= S_SETTLE;
          cnt <= at_least1(cfg_settle) - ONE;
        end else cnt <= cnt - ONE;
        S_SETTLE: if (cnt == '0) begin
          st  <= S_SENSE;
          cnt <= at_least1(cfg_sense) - ONE;
        end else cnt <= cnt - ONE;
        S_SENSE: if (cnt == '0) begin
          st       <= S_IDLE;
          rd_data  <= sensed;
          rd_valid <= 1'b1;
        end else cnt <= cnt - ONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  logic [CNT_W:0] wr_run;
  always_ff @(posedge clk) begin
    if (!rst_n) wr_run <= '0;
    else        wr_run <= (|wr_en) ? wr_run + 1'b1 : '0;
  end

  AST_PULSE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    (|wr_en) |-> (wr_run < (CNT_W+1)'(MAX_PULSE))); // R4
  AST_DISCHARGE_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|wr_en) |-> (dis_en == $past(wr_en))); // R5
  AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_en || sa_strobe) |-> (wr_en == '0)); // R11
  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({|wr_en, |dis_en, pre_en, sa_strobe})); // R6
  AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sa_strobe) |-> rd_valid); // R7
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |=> !rd_valid); // R7
  AST_BIAS_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_bias & ~wr_en) == '0)); // R3

endmodule

// File: tb/tb_pcm_seq.sv
module tb_pcm_seq;
  localparam int NCOL = 256;
  logic clk = 0, rst_n = 0;
  always #5 clk = ~clk;

  logic        req_valid = 0, req_write = 0, diff_mode = 0;
  logic [11:0] req_addr = 0;
  logic [15:0] req_wdata = 0;
  logic [7:0]  cfg_pulse = 5, cfg_discharge = 3, cfg_precharge = 2, cfg_settle = 2, cfg_sense = 2;
  logic        busy, row_en, pre_en, sa_strobe, rd_valid;
  logic [7:0]  row_addr;
  logic [3:0]  col_sel;
  logic [NCOL-1:0] wr_en, wr_bias, dis_en;
  logic [15:0] sa_out = 0, rd_data;

  pcm_seq dut (.clk, .rst_n, .req_valid, .req_write, .req_addr, .req_wdata, .diff_mode,
    .cfg_pulse, .cfg_discharge, .cfg_precharge, .cfg_settle, .cfg_sense,
    .busy, .row_en, .row_addr, .col_sel, .wr_en, .wr_bias, .dis_en, .pre_en,
    .sa_strobe, .sa_out, .rd_data, .rd_valid);

  int compared = 0, mismatched = 0;
  bit done = 0;
  bit cells [int];
  bit expc  [int];
  logic [15:0] expq [$];

  task automatic chk(input bit ok, input string req, input logic [NCOL-1:0] act, input logic [NCOL-1:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit getc(input bit tbl [int], input int key);
    return tbl.exists(key) ? tbl[key] : 1'b0;
  endfunction

  always @(negedge clk) begin
    if (|wr_en)
      for (int k = 0; k < NCOL; k++)
        if (wr_en[k]) cells[row_addr*NCOL + k] = wr_bias[k];
    if (sa_strobe)
      for (int g = 0; g < 16; g++) sa_out[g] = getc(cells, row_addr*NCOL + g*16 + col_sel);
    else sa_out = '0;
  end

  always @(negedge clk) begin
    if (rst_n && rd_valid) begin
      if (expq.size() == 0) chk(0, "R7 unexpected rd_valid", 0, 0);
      else begin
        logic [15:0] e;
        e = expq.pop_front();
        chk(rd_data == e, "R7/R9 read data", rd_data, e);
      end
    end
  end

  function automatic logic [15:0] grp_bias(input logic [15:0] d, input bit dm);
    logic [15:0] b;
    for (int g = 0; g < 16; g++) b[g] = dm ? ((g % 2 == 0) ? d[g/2] : ~d[g/2]) : d[g];
    return b;
  endfunction

  task automatic do_write(input logic [11:0] a, input logic [15:0] d, input bit dm,
                          input logic [7:0] pl, input bit intrude);
    logic [NCOL-1:0] m, b;
    logic [15:0] gb;
    int n, x, ep;
    gb = grp_bias(d, dm);
    m = '0; b = '0;
    for (int g = 0; g < 16; g++) begin
      m[g*16 + a[11:8]] = 1'b1;
      b[g*16 + a[11:8]] = gb[g];
      expc[a[7:0]*NCOL + g*16 + a[11:8]] = gb[g];
    end
    ep = (pl == 0) ? 1 : (pl > 40) ? 40 : pl;
    while (busy) @(negedge clk);
    cfg_pulse = pl;
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d; diff_mode = dm;
    @(negedge clk);
    req_valid = 0;
    chk(row_en && row_addr == a[7:0] && col_sel == a[11:8], "R2 write address", {row_addr, col_sel}, a);
    if (intrude) begin
      req_valid = 1; req_write = 1; req_addr = 12'h3C7; req_wdata = 16'hFFFF; diff_mode = 0;
    end
    n = 0;
    while (|wr_en && n < 100) begin
      chk(wr_en == m, dm ? "R8 write enables" : "R3 write enables", wr_en, m);
      chk(wr_bias == b, dm ? "R8 write bias" : "R3 write bias", wr_bias, b);
      n++; @(negedge clk);
    end
    chk(n == ep, "R4 pulse length", n, ep);
    x = 0;
    while (|dis_en && x < 100) begin
      chk(dis_en == m && wr_en == '0, "R5 discharge columns", dis_en, m);
      x++; @(negedge clk);
    end
    chk(x == ((cfg_discharge == 0) ? 1 : cfg_discharge), "R5 discharge length", x, cfg_discharge);
    chk(!busy, "R5 busy falls", busy, 0);
    req_valid = 0;
  endtask

  task automatic do_read(input logic [11:0] a, input bit dm);
    logic [15:0] s, e;
    int p, t, n;
    for (int g = 0; g < 16; g++) s[g] = getc(expc, a[7:0]*NCOL + g*16 + a[11:8]);
    if (dm) begin
      e = '0;
      for (int i = 0; i < 8; i++) e[i] = s[2*i] & ~s[2*i+1];
    end else e = s;
    while (busy) @(negedge clk);
    req_valid = 1; req_write = 0; req_addr = a; diff_mode = dm;
    expq.push_back(e);
    @(negedge clk);
    req_valid = 0;
    p = 0; t = 0; n = 0;
    while (pre_en && p < 100) begin
      chk(wr_en == '0 && !sa_strobe, "R11 no drive in precharge", wr_en, 0);
      p++; @(negedge clk);
    end
    while (busy && !sa_strobe && t < 100) begin
      chk(wr_en == '0 && !pre_en && row_en, "R6 settle gap", {pre_en, wr_en}, 0);
      t++; @(negedge clk);
    end
    while (sa_strobe && n < 100) begin
      chk(row_en && row_addr == a[7:0] && col_sel == a[11:8], "R2 read address", {row_addr, col_sel}, a);
      chk(wr_en == '0, "R11 no drive in sense", wr_en, 0);
      n++; @(negedge clk);
    end
    chk(p == ((cfg_precharge == 0) ? 1 : cfg_precharge), "R6 precharge length", p, cfg_precharge);
    chk(t == ((cfg_settle == 0) ? 1 : cfg_settle), "R6 settle length", t, cfg_settle);
    chk(n == ((cfg_sense == 0) ? 1 : cfg_sense), "R6 sense length", n, cfg_sense);
    chk(rd_valid && !busy, "R7 valid after strobe", {rd_valid, busy}, 2'b10);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !row_en && !pre_en && !sa_strobe && !rd_valid, "R1 reset controls",
        {busy, row_en, pre_en, sa_strobe, rd_valid}, 0);
    chk(wr_en == '0 && wr_bias == '0 && dis_en == '0, "R1 reset drivers", wr_en | wr_bias | dis_en, 0);
    rst_n = 1;
    @(negedge clk);
    do_read(12'h512, 0);                              // unwritten reads 0
    do_write(12'h512, 16'hA5C3, 0, 8'd5, 0);          // R3
    do_read(12'h512, 0);
    do_read(12'h512, 0);                              // R11 repeat read
    do_write(12'hF00, 16'h5555, 0, 8'd0, 0);          // R4 zero -> 1
    do_write(12'h0FF, 16'hAAAA, 0, 8'd60, 0);         // R4 clamp 40
    do_write(12'h8FF, 16'hFFFF, 0, 8'd40, 0);
    cfg_precharge = 0; cfg_settle = 4; cfg_sense = 1; cfg_discharge = 0;
    do_read(12'hF00, 0);
    do_read(12'h0FF, 0);
    do_read(12'h8FF, 0);
    cfg_precharge = 3; cfg_settle = 0; cfg_sense = 3; cfg_discharge = 2;
    do_write(12'h2A0, 16'h00B6, 1, 8'd7, 0);          // R8
    do_read(12'h2A0, 1);                              // R9
    do_read(12'h2A0, 0);                              // pair view
    do_write(12'h2A0, 16'hFF49, 1, 8'd3, 0);
    do_read(12'h2A0, 1);
    do_read(12'h512, 1);                              // R9 single data read as pairs
    do_write(12'h700, 16'h1234, 0, 8'd6, 1);          // R10 intruding request
    do_read(12'h3C7, 0);                              // R10 must still be 0
    do_read(12'h700, 0);
    repeat (4) @(negedge clk);
    chk(expq.size() == 0, "R7 every read returned", expq.size(), 0);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      compared++; mismatched++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule